// File: doc/BRIEF.md
# Header Template Streamer

This block holds a header template that software loads through a simple write port. Each template slot has 16 data bits and six control flags. When a packet is launched, the block sends the template as a stream of 16-bit words, one slot per accepted transfer, starting at slot 2. The stream ends at the slot that carries the end flag. A flag in a slot can replace the stored data with a value computed for this packet: the IPv4 total length, the UDP length, the finished IPv4 header checksum, or a UDP source or destination port. The ports come from a small table that has a data entry and an error entry for each of two channels.

Software pre-folds the constant IPv4 header words into the stored checksum word. At run time the block adds only the per-packet total length, folds the carry back in, and inverts the result. The payload byte count, the channel and the data/error choice are latched at launch. They cannot change while the header is being sent. The output is a valid/ready stream with first-word and last-word markers.

The sequencer has two states. In `ST_IDLE` the block waits for a launch. In `ST_EMIT` it presents one slot per cycle. There are three transitions:
- LAUNCH: `ST_IDLE` to `ST_EMIT`, when `start` is high.
- ADVANCE: `ST_EMIT` to `ST_EMIT`, on an accepted word that is not the last.
- FINISH: `ST_EMIT` to `ST_IDLE`, on an accepted last word.

Top module: `hdr_stream`

## Requirements
- R1: After reset the block is idle (`idle`=1, `out_valid`=0). Every template slot and every port-table entry reads as zero (data 0, no flags).
- R2: A `start` pulse while idle latches `pay_len`, `chan_sel` and `err_sel`. On the next cycle `out_valid` rises with `out_first`=1 and the word of slot 2. A `start` while the stream is running is ignored and does not change the latched values.
- R3: Words come out in ascending slot order. The slot advances only on a cycle with `out_valid` and `out_ready` both high. While `out_ready` is low, `out_data`, `out_first` and `out_last` hold their values.
- R4: `out_last` is high for a slot whose flag bit 19 is set, and also for the final slot (DEPTH-1). After the last word is accepted, the block is idle on the next cycle. Before that, `out_valid` never drops.
- R5: A slot with no substitution flag outputs its stored bits 15:0 unchanged.
- R6: Flag bit 17 outputs the IPv4 total length, (payload bytes + 28) mod 65536, and ignores the stored data.
- R7: Flag bit 16 outputs the UDP length, (payload bytes + 8) mod 65536, and ignores the stored data.
- R8: Flag bit 18 outputs ~F. Here S = stored + IPv4 total length as a 17-bit sum, and F = S[15:0] + S[16].
- R9: Flag bit 21 outputs a source port and flag bit 20 outputs a destination port, both from the port table. Table entry k is written at address DEPTH+k, with k = {chan, err, half}. half=0 is the source port and half=1 is the destination port.
- R10: If several substitution flags are set in one slot, the highest-numbered flag wins. The order is 21, then 20, then 18, then 17, then 16.
- R11: Flag bit 19 can be combined with any substitution flag. The word is then substituted and also ends the stream.
- R12: A write with `cfg_we` high stores `cfg_wdata[21:0]` in template slot `cfg_addr` when `cfg_addr` < DEPTH. It stores bits 15:0 in the port table for addresses DEPTH to DEPTH+7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for template and port table |
| cfg_addr | input | 5 | Write address (ADDR_W) |
| cfg_wdata | input | 22 | Flags in 21:16, data in 15:0 |
| start | input | 1 | Launch a header |
| pay_len | input | 16 | Payload byte count for this packet |
| chan_sel | input | 1 | Channel for port substitution |
| err_sel | input | 1 | Select error port instead of data port |
| idle | output | 1 | High when a launch is accepted |
| out_valid | output | 1 | Word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | 16 | Header word |
| out_first | output | 1 | First word of the header |
| out_last | output | 1 | Last word of the header |

## Verification
Some rules are checked by assertions on every cycle:
- the output holds steady while the consumer stalls;
- a launch produces a first word on the next cycle;
- the stream never stops before its last word is accepted;
- the block returns to idle right after that word.

The arithmetic content of each word can only be shown by the bench's scenarios. This covers the two lengths, the checksum fold, the port choice across channel and error settings, and the flag priority. So is the ignoring of a launch in mid-stream, and the forced end at the final slot. The bench sweeps payload lengths up to the 16-bit wrap, over all four channel/error combinations, under a repeating stall pattern.

// File: rtl/hdr_stream_pkg.sv
package hdr_stream_pkg;
    localparam int WORD_W  = 16;
    localparam int FLAG_W  = 6;
    localparam int ENTRY_W = WORD_W + FLAG_W;

    // flag positions inside the flag field (entry bit = 16 + position)
    localparam int FL_UDP_LEN = 0;
    localparam int FL_IP_LEN  = 1;
    localparam int FL_CSUM    = 2;
    localparam int FL_END     = 3;
    localparam int FL_DST     = 4;
    localparam int FL_SRC     = 5;

    typedef struct packed {
        logic [FLAG_W-1:0] flags;
        logic [WORD_W-1:0] data;
    } tmpl_entry_t;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_EMIT = 1'b1
    } seq_state_t;
endpackage

// File: rtl/hdr_tmpl_store.sv
module hdr_tmpl_store
    import hdr_stream_pkg::*;
#(
    parameter int DEPTH  = 24,
    parameter int ADDR_W = 5,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  tmpl_entry_t         wdata,
    input  logic [IDX_W-1:0]    rd_slot,
    input  logic [1:0]          port_sel,
    output tmpl_entry_t         rd_entry,
    output logic [WORD_W-1:0]   src_port,
    output logic [WORD_W-1:0]   dst_port
);
    localparam int PORT_N    = 8;
    localparam int PORT_BASE = DEPTH;

    tmpl_entry_t       slots_q [DEPTH];
    logic [WORD_W-1:0] ports_q [PORT_N];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) slots_q[i] <= '0;
            for (int p = 0; p < PORT_N; p++) ports_q[p] <= '0;
        end else if (we) begin
            for (int i = 0; i < DEPTH; i++)
                if (int'(addr) == i) slots_q[i] <= wdata;
            for (int p = 0; p < PORT_N; p++)
                if (int'(addr) == PORT_BASE + p) ports_q[p] <= wdata.data;
        end
    end

    always_comb begin
        rd_entry = '0;
        if (int'(rd_slot) < DEPTH) rd_entry = slots_q[rd_slot];
        src_port = ports_q[{port_sel, 1'b0}];
        dst_port = ports_q[{port_sel, 1'b1}];
    end
endmodule

// File: rtl/hdr_field_sub.sv
module hdr_field_sub
    import hdr_stream_pkg::*;
#(
    parameter int IP_OVERHEAD  = 28,
    parameter int UDP_OVERHEAD = 8
) (
    input  tmpl_entry_t       entry,
    input  logic [WORD_W-1:0] pay_bytes,
    input  logic [WORD_W-1:0] src_port,
    input  logic [WORD_W-1:0] dst_port,
    output logic [WORD_W-1:0] word,
    output logic              end_flag
);
    logic [WORD_W-1:0] ip_total;
    logic [WORD_W-1:0] udp_total;
    logic [WORD_W:0]   csum_sum;
    logic [WORD_W-1:0] csum_fold;

    always_comb begin
        ip_total  = pay_bytes + WORD_W'(IP_OVERHEAD);
        udp_total = pay_bytes + WORD_W'(UDP_OVERHEAD);
        csum_sum  = {1'b0, entry.data} + {1'b0, ip_total};
        csum_fold = csum_sum[WORD_W-1:0] + {{(WORD_W-1){1'b0}}, csum_sum[WORD_W]};
        end_flag  = entry.flags[FL_END];

        if (entry.flags[FL_SRC])          word = src_port;
        else if (entry.flags[FL_DST])     word = dst_port;
        else if (entry.flags[FL_CSUM])    word = ~csum_fold;
        else if (entry.flags[FL_IP_LEN])  word = ip_total;
        else if (entry.flags[FL_UDP_LEN]) word = udp_total;
        else                              word = entry.data;
    end
endmodule

// File: rtl/hdr_seq_fsm.sv
module hdr_seq_fsm
    import hdr_stream_pkg::*;
#(
    parameter int DEPTH      = 24,
    parameter int FIRST_SLOT = 2,
    localparam int IDX_W     = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             end_word,
    input  logic             out_ready,
    output logic [IDX_W-1:0] slot,
    output logic             load,
    output logic             idle,
    output logic             out_valid,
    output logic             out_first
);
    seq_state_t       state_q, state_d;
    logic [IDX_W-1:0] slot_q, slot_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            slot_q  <= IDX_W'(FIRST_SLOT);
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
        end
    end

    // transitions: LAUNCH, ADVANCE, FINISH
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_EMIT;
                    slot_d  = IDX_W'(FIRST_SLOT);
                end
            end
            ST_EMIT: begin
                if (out_ready) begin
                    if (end_word) state_d = ST_IDLE;
                    else          slot_d  = slot_q + IDX_W'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        slot      = slot_q;
        idle      = (state_q == ST_IDLE);
        out_valid = (state_q == ST_EMIT);
        out_first = out_valid && (slot_q == IDX_W'(FIRST_SLOT));
        load      = idle && start;
    end
endmodule

// File: rtl/hdr_stream.sv
module hdr_stream
    import hdr_stream_pkg::*;
#(
    parameter int DEPTH        = 24,
    parameter int ADDR_W       = 5,
    parameter int FIRST_SLOT   = 2,
    parameter int IP_OVERHEAD  = 28,
    parameter int UDP_OVERHEAD = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [21:0]       cfg_wdata,
    input  logic              start,
    input  logic [15:0]       pay_len,
    input  logic              chan_sel,
    input  logic              err_sel,
    output logic              idle,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_data,
    output logic              out_first,
    output logic              out_last
);
    localparam int IDX_W = $clog2(DEPTH);

    logic [IDX_W-1:0]  slot;
    logic              load;
    logic              end_flag;
    logic              end_word;
    tmpl_entry_t       entry;
    logic [WORD_W-1:0] src_port, dst_port;
    logic [WORD_W-1:0] len_q;
    logic [1:0]        sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            len_q <= '0;
            sel_q <= '0;
        end else if (load) begin
            len_q <= pay_len;
            sel_q <= {chan_sel, err_sel};
        end
    end

    hdr_tmpl_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(tmpl_entry_t'(cfg_wdata)), .rd_slot(slot), .port_sel(sel_q),
        .rd_entry(entry), .src_port(src_port), .dst_port(dst_port)
    );

    hdr_field_sub #(.IP_OVERHEAD(IP_OVERHEAD), .UDP_OVERHEAD(UDP_OVERHEAD)) u_sub (
        .entry(entry), .pay_bytes(len_q), .src_port(src_port),
        .dst_port(dst_port), .word(out_data), .end_flag(end_flag)
    );

    assign end_word = end_flag || (slot == IDX_W'(DEPTH - 1));
    assign out_last = out_valid && end_word;

    hdr_seq_fsm #(.DEPTH(DEPTH), .FIRST_SLOT(FIRST_SLOT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .end_word(end_word),
        .out_ready(out_ready), .slot(slot), .load(load), .idle(idle),
        .out_valid(out_valid), .out_first(out_first)
    );
endmodule

// File: rtl/hdr_stream_chk.sv
module hdr_stream_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic        start,
    input logic        idle,
    input logic        out_valid,
    input logic        out_ready,
    input logic [15:0] out_data,
    input logic        out_first,
    input logic        out_last
);
    a_r2_launch_first: assert property (@(posedge clk) disable iff (!rst_n)
        idle && start |=> out_valid && out_first);

    a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready && !cfg_we |=>
            out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));

    a_r3_first_advances: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_first |=> !out_first);

    a_r4_no_early_stop: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !(out_ready && out_last) |=> out_valid);

    a_r4_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> idle && !out_valid);
endmodule

bind hdr_stream hdr_stream_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .start(start), .idle(idle),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
);

// File: tb/hdr_stream_test.sv
`timescale 1ns/1ps
module hdr_stream_test;
    localparam int DEPTH = 24;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [21:0] cfg_wdata = '0;
    logic        start = 1'b0;
    logic [15:0] pay_len = '0;
    logic        chan_sel = 1'b0;
    logic        err_sel = 1'b0;
    logic        idle, out_valid, out_first, out_last;
    logic        out_ready = 1'b0;
    logic [15:0] out_data;

    int n_tests = 0;
    int n_fail  = 0;

    logic [21:0] tm [DEPTH];
    logic [15:0] pt [8];

    always #5 clk = ~clk;

    hdr_stream uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .start(start), .pay_len(pay_len),
        .chan_sel(chan_sel), .err_sel(err_sel), .idle(idle),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_first(out_first), .out_last(out_last)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int addr, input logic [21:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(addr); cfg_wdata = d;
        if (addr < DEPTH) tm[addr] = d;
        else pt[addr-DEPTH] = d[15:0];
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [15:0] exp_word(input int s, input logic [15:0] len,
                                             input logic ch, input logic er);
        logic [5:0]  f;
        logic [15:0] d, ipl, udl, fold;
        logic [16:0] sum;
        f = tm[s][21:16]; d = tm[s][15:0];
        ipl = len + 16'd28; udl = len + 16'd8;
        sum = {1'b0, d} + {1'b0, ipl};
        fold = sum[15:0] + {15'b0, sum[16]};
        if (f[5])      return pt[{ch, er, 1'b0}];
        else if (f[4]) return pt[{ch, er, 1'b1}];
        else if (f[2]) return ~fold;
        else if (f[1]) return ipl;
        else if (f[0]) return udl;
        return d;
    endfunction

    function automatic string req_of(input int s);
        logic [5:0] f;
        f = tm[s][21:16];
        if (f[5] || f[4]) return (f[2:0] != 0) ? "R10" : "R9";
        if (f[2]) return (f[1:0] != 0) ? "R10" : "R8";
        if (f[1]) return (f[0]) ? "R10" : "R6";
        if (f[0]) return "R7";
        return "R5";
    endfunction

    // Launch one header and follow it word by word.
    task automatic run_packet(input logic [15:0] len, input logic ch, input logic er,
                              input int seed, input bit inject);
        int  s = 2;
        int  cyc = 0;
        bit  lst, rdy;
        @(negedge clk);
        start = 1'b1; pay_len = len; chan_sel = ch; err_sel = er;
        @(negedge clk);
        start = 1'b0;
        forever begin
            rdy = ((cyc * 7 + seed) % 3) != 0;
            out_ready = rdy;
            lst = tm[s][19] || (s == DEPTH - 1);
            chk(out_valid === 1'b1, "R3", int'(out_valid), 1);
            chk(out_data === exp_word(s, len, ch, er), req_of(s),
                int'(out_data), int'(exp_word(s, len, ch, er)));
            chk(out_first === (s == 2), "R2", int'(out_first), int'(s == 2));
            chk(out_last === lst, (tm[s][19] && tm[s][21:16] != 6'h08) ? "R11" : "R4",
                int'(out_last), int'(lst));
            if (inject && cyc == 2) begin
                // R2: launch during streaming must be ignored
                start = 1'b1; pay_len = len ^ 16'h5A5A; chan_sel = ~ch; err_sel = ~er;
            end
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (cyc > 400) begin
                chk(1'b0, "R4", cyc, 0);
                break;
            end
            if (rdy) begin
                if (lst) break;
                s++;
            end
        end
        out_ready = 1'b0;
        chk(idle === 1'b1 && out_valid === 1'b0, "R4", int'({idle, out_valid}), 2);
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) tm[i] = '0;
        for (int p = 0; p < 8; p++) pt[p] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(idle === 1'b1, "R1", int'(idle), 1);
        chk(out_valid === 1'b0, "R1", int'(out_valid), 0);
        // R1: zeroed template streams zeros to the final slot (R4 forced end)
        run_packet(16'd100, 1'b1, 1'b0, 0, 1'b0);

        // R12: load a header template and port table
        for (int i = 2; i <= 8; i++) wr(i, 22'(16'h1100 + i));
        wr(9,  {6'h00, 16'h4500});
        wr(10, {6'h02, 16'hABCD});   // IP total length
        wr(11, {6'h00, 16'h0000});
        wr(12, {6'h00, 16'h4000});
        wr(13, {6'h00, 16'h4011});
        wr(14, {6'h04, 16'hF00D});   // checksum (pre-folded)
        for (int i = 15; i <= 18; i++) wr(i, 22'(16'hC0A8 + i));
        wr(19, {6'h20, 16'h0000});   // source port
        wr(20, {6'h10, 16'h0000});   // destination port
        wr(21, {6'h01, 16'h7777});   // UDP length
        wr(22, {6'h08, 16'h0000});   // last
        for (int k = 0; k < 8; k++) wr(DEPTH + k, 22'(16'h8000 + k * 16'h0111));

        // sweep lengths and channel/error selections
        for (int li = 0; li < 6; li++) begin
            for (int sel = 0; sel < 4; sel++) begin
                logic [15:0] ln;
                case (li)
                    0: ln = 16'd0;
                    1: ln = 16'd1;
                    2: ln = 16'd28;
                    3: ln = 16'd1000;
                    4: ln = 16'd65507;
                    default: ln = 16'd65535;
                endcase
                run_packet(ln, sel[1], sel[0], li + sel, 1'b0);
            end
        end

        // R2: start while busy is ignored
        run_packet(16'd512, 1'b0, 1'b1, 1, 1'b1);

        // R10 priority and R11 combined end flag
        wr(3, {6'h31, 16'h1234});
        wr(4, {6'h07, 16'hFFFF});
        wr(5, {6'h11, 16'h2222});
        wr(6, {6'h28, 16'h3333});
        run_packet(16'd64, 1'b1, 1'b1, 2, 1'b0);
        run_packet(16'd65535, 1'b0, 1'b0, 0, 1'b0);

        // R4: no end flag anywhere -> forced end at slot DEPTH-1
        wr(6, {6'h00, 16'h3333});
        wr(22, {6'h00, 16'h0000});
        run_packet(16'd300, 1'b1, 1'b0, 1, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule